// File: doc/BRIEF.md
# Chained Hash Job Sequencer

This block drives a hash engine through a multi-segment job without processor help. Software first fills a small descriptor table. Each entry gives a source address, a source length counted in 32-bit words, and a result address. Software then starts a job with a flow choice, a method code and a timeout. For each valid entry the sequencer writes the engine's registers one per cycle over a simple write port. The write to the control register, which starts the engine, is always the last of these writes. The sequencer then waits for the engine's completion pulse.

Segments after the first continue a running hash. Their control word carries a continuation bit, and the previous segment's result address is written first as both the key/state address and the IV address. A job ends in one of two ways. It ends normally at the first entry whose result address is zero, or after the last table entry. It ends with an error when a segment's wait runs out; no further segments are issued after an error.

Top module: `hash_chain_seq`

## Requirements
- R1: `job_go` is only taken while idle. `busy` goes high the cycle after it is taken and stays high until the cycle `job_done` or `job_err` pulses, when it falls. A `job_go` while busy changes nothing.
- R2: Each segment issues, in consecutive cycles, the source-address write (select 2), the result-address write (select 3), the length write (select 4), the interrupt-enable write (select 5) and the control write (select 6). There is no gap between them and the control write is last. A segment starts two idle cycles after the job is taken or after the previous segment completes.
- R3: Every segment except the first is preceded, in the same run of writes, by a key/state-address write (select 0) and then an IV-address write (select 1). Both carry the previous segment's result address. Bit 17 of the control word is 1 on those segments and 0 on the first.
- R4: The control word has bit 0 set (start), bit 1 equal to the job's flow (0 or 1), the method code in bits starting at bit 4, and every other bit zero apart from bit 17.
- R5: The length write carries the source word count zero-extended. The interrupt-enable write carries the value 3.
- R6: A job ends with a one-cycle `job_done` pulse in the cycle after it reaches a descriptor whose result address is zero, or after the completion of the last table entry. If the first entry's result address is zero, no writes are issued at all.
- R7: The wait for a segment covers T cycles, counted from the cycle its control write appears (T below 1 acts as 1). If no completion arrives, `job_err` pulses in the next cycle and no later segment is issued.
- R8: A completion pulse outside a segment's wait window has no effect.
- R9: A completion arriving in the last cycle of the wait window counts as success and the job continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_idx | input | IDXW | Descriptor index to write |
| tbl_src_addr | input | 32 | Source address of the entry |
| tbl_src_words | input | LW | Source length in 32-bit words |
| tbl_res_addr | input | 32 | Result address; zero ends the chain |
| job_go | input | 1 | Start a job (taken when idle) |
| job_flow | input | 1 | Flow select for the job |
| job_method | input | MW | Method code for the job |
| job_timeout | input | TW | Wait limit per segment, in cycles |
| eng_done | input | 1 | Completion pulse from the engine |
| eng_wr_en | output | 1 | Engine register write strobe |
| eng_wr_sel | output | 3 | Engine register select |
| eng_wr_data | output | 32 | Engine register write data |
| busy | output | 1 | Job in progress |
| job_done | output | 1 | Job finished normally (pulse) |
| job_err | output | 1 | Job aborted on a timeout (pulse) |

## Verification
Two things can happen in the same cycle: the engine's completion pulse and the expiry of the segment timer. The bench provokes this by having its engine stub answer in exactly the last allowed wait cycle, with the delay set equal to the timeout. The outcome is judged by the next segment's key and IV writes following, with no error pulse. A second overlap puts a stray completion pulse on the same cycle as a register write before the control word. The stub is then made silent, so the expected result is a timeout error rather than progress.

// File: rtl/hash_chain_pkg.sv
package hash_chain_pkg;

  typedef enum logic [2:0] {
    REG_KEY = 3'd0,
    REG_IV  = 3'd1,
    REG_SRC = 3'd2,
    REG_DST = 3'd3,
    REG_LEN = 3'd4,
    REG_IEN = 3'd5,
    REG_CTL = 3'd6
  } eng_reg_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_IV, S_SRC, S_DST, S_LEN, S_IEN, S_CTL, S_WAIT
  } seq_state_e;

  localparam int CTL_START_BIT  = 0;
  localparam int CTL_FLOW_BIT   = 1;
  localparam int CTL_METHOD_LSB = 4;
  localparam int CTL_CHAIN_BIT  = 17;
  localparam logic [31:0] IEN_VALUE = 32'h0000_0003;

endpackage

// File: rtl/desc_table.sv
module desc_table #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 80,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/seg_timer.sv
module seg_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);

  logic [TW:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt <= '0;
    else if (run && !cnt[TW])      cnt <= cnt + 1'b1;
  end

  assign expire = run && ((cnt + 1'b1) >= {1'b0, limit});

endmodule

// File: rtl/hash_chain_seq.sv
module hash_chain_seq
  import hash_chain_pkg::*;
#(
  parameter int N_SEG = 4,
  parameter int LW    = 16,
  parameter int MW    = 4,
  parameter int TW    = 16,
  localparam int IDXW = (N_SEG > 1) ? $clog2(N_SEG) : 1,
  localparam int DW   = 64 + LW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tbl_we,
  input  logic [IDXW-1:0] tbl_idx,
  input  logic [31:0]     tbl_src_addr,
  input  logic [LW-1:0]   tbl_src_words,
  input  logic [31:0]     tbl_res_addr,
  input  logic            job_go,
  input  logic            job_flow,
  input  logic [MW-1:0]   job_method,
  input  logic [TW-1:0]   job_timeout,
  input  logic            eng_done,
  output logic            eng_wr_en,
  output logic [2:0]      eng_wr_sel,
  output logic [31:0]     eng_wr_data,
  output logic            busy,
  output logic            job_done,
  output logic            job_err
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N_SEG - 1);

  seq_state_e      state;
  logic [IDXW-1:0] idx;
  logic            flow_q;
  logic [MW-1:0]   method_q;
  logic [TW-1:0]   tmo_q;
  logic [31:0]     prev_res;
  logic [DW-1:0]   rd_desc;
  logic [31:0]     rd_src, rd_res, ctl_word;
  logic [LW-1:0]   rd_len;
  logic            tmr_expire;

  desc_table #(.DEPTH(N_SEG), .WIDTH(DW)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_idx),
    .wdata ({tbl_src_addr, tbl_src_words, tbl_res_addr}),
    .raddr (idx),
    .rdata (rd_desc)
  );

  assign rd_src = rd_desc[DW-1 -: 32];
  assign rd_len = rd_desc[32 +: LW];
  assign rd_res = rd_desc[31:0];

  seg_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (state == S_CTL),
    .run    (state == S_WAIT),
    .limit  (tmo_q),
    .expire (tmr_expire)
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_START_BIT] = 1'b1;
    ctl_word[CTL_FLOW_BIT]  = flow_q;
    ctl_word[CTL_METHOD_LSB +: MW] = method_q;
    ctl_word[CTL_CHAIN_BIT] = (idx != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      idx         <= '0;
      flow_q      <= 1'b0;
      method_q    <= '0;
      tmo_q       <= '0;
      prev_res    <= '0;
      eng_wr_en   <= 1'b0;
      eng_wr_sel  <= '0;
      eng_wr_data <= '0;
      busy        <= 1'b0;
      job_done    <= 1'b0;
      job_err     <= 1'b0;
    end else begin
      eng_wr_en <= 1'b0;
      job_done  <= 1'b0;
      job_err   <= 1'b0;
      case (state)
        S_IDLE: if (job_go) begin
          state    <= S_FETCH;
          idx      <= '0;
          busy     <= 1'b1;
          flow_q   <= job_flow;
          method_q <= job_method;
          tmo_q    <= job_timeout;
        end
        S_FETCH: state <= S_CHECK;
        S_CHECK: begin
          if (rd_res == '0) begin
            job_done <= 1'b1;
            busy     <= 1'b0;
            state    <= S_IDLE;
          end else if (idx != '0) begin
            eng_wr_en <= 1'b1; eng_wr_sel <= REG_KEY; eng_wr_data <= prev_res;
            state <= S_IV;
          end else begin
            eng_wr_en <= 1'b1; eng_wr_sel <= REG_SRC; eng_wr_data <= rd_src;
            state <= S_DST;
          end
        end
        S_IV: begin
          eng_wr_en <= 1'b1; eng_wr_sel <= REG_IV; eng_wr_data <= prev_res;
          state <= S_SRC;
        end
        S_SRC: begin
          eng_wr_en <= 1'b1; eng_wr_sel <= REG_SRC; eng_wr_data <= rd_src;
          state <= S_DST;
        end
        S_DST: begin
          eng_wr_en <= 1'b1; eng_wr_sel <= REG_DST; eng_wr_data <= rd_res;
          state <= S_LEN;
        end
        S_LEN: begin
          eng_wr_en <= 1'b1; eng_wr_sel <= REG_LEN;
          eng_wr_data <= {{(32-LW){1'b0}}, rd_len};
          state <= S_IEN;
        end
        S_IEN: begin
          eng_wr_en <= 1'b1; eng_wr_sel <= REG_IEN; eng_wr_data <= IEN_VALUE;
          state <= S_CTL;
        end
        S_CTL: begin
          eng_wr_en <= 1'b1; eng_wr_sel <= REG_CTL; eng_wr_data <= ctl_word;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (eng_done) begin
            prev_res <= rd_res;
            if (idx == LAST_IDX) begin
              job_done <= 1'b1;
              busy     <= 1'b0;
              state    <= S_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_FETCH;
            end
          end else if (tmr_expire) begin
            job_err <= 1'b1;
            busy    <= 1'b0;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (job_done || job_err) |-> !busy); // R1
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_wr_en |-> busy); // R1
  AST_KEY_THEN_IV: assert property (@(posedge clk) disable iff (rst)
    (eng_wr_en && eng_wr_sel == REG_KEY) |=>
    (eng_wr_en && eng_wr_sel == REG_IV && $stable(eng_wr_data))); // R3
  AST_IEN_THEN_CTL: assert property (@(posedge clk) disable iff (rst)
    (eng_wr_en && eng_wr_sel == REG_IEN) |=> (eng_wr_en && eng_wr_sel == REG_CTL)); // R2
  AST_CTL_STARTS: assert property (@(posedge clk) disable iff (rst)
    (eng_wr_en && eng_wr_sel == REG_CTL) |-> eng_wr_data[CTL_START_BIT]); // R4
  AST_IEN_BITS: assert property (@(posedge clk) disable iff (rst)
    (eng_wr_en && eng_wr_sel == REG_IEN) |-> (eng_wr_data == IEN_VALUE)); // R5
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    job_done |-> !job_err); // R6
  AST_ERR_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
    $rose(job_err) |-> $past(busy)); // R7

endmodule

// File: tb/test_hash_chain_seq.sv
module test_hash_chain_seq;
  localparam int N = 4, LW = 16, MW = 4, TW = 16, IDXW = 2;
  localparam logic [2:0] K_KEY = 3'd0, K_IV = 3'd1, K_SRC = 3'd2, K_DST = 3'd3,
                         K_LEN = 3'd4, K_IEN = 3'd5, K_CTL = 3'd6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, tbl_we, job_go, job_flow, eng_done;
  logic [IDXW-1:0] tbl_idx;
  logic [31:0] tbl_src_addr, tbl_res_addr;
  logic [LW-1:0] tbl_src_words;
  logic [MW-1:0] job_method;
  logic [TW-1:0] job_timeout;
  logic eng_wr_en, busy, job_done, job_err;
  logic [2:0] eng_wr_sel;
  logic [31:0] eng_wr_data;

  hash_chain_seq #(.N_SEG(N), .LW(LW), .MW(MW), .TW(TW)) i_hash_chain_seq (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_src_addr(tbl_src_addr), .tbl_src_words(tbl_src_words),
    .tbl_res_addr(tbl_res_addr), .job_go(job_go), .job_flow(job_flow),
    .job_method(job_method), .job_timeout(job_timeout), .eng_done(eng_done),
    .eng_wr_en(eng_wr_en), .eng_wr_sel(eng_wr_sel), .eng_wr_data(eng_wr_data),
    .busy(busy), .job_done(job_done), .job_err(job_err));

  int checks = 0, errors = 0;
  logic [31:0]   t_src [N];
  logic [LW-1:0] t_len [N];
  logic [31:0]   t_res [N];
  int            dly   [N];
  logic [38:0]   exp_q [$];
  string         tag_q [$];

  function automatic logic [38:0] actual();
    return {busy, job_done, job_err, eng_wr_en,
            eng_wr_en ? eng_wr_sel : 3'd0, eng_wr_en ? eng_wr_data : 32'd0};
  endfunction

  task automatic push(bit b, bit dn, bit er, bit we, logic [2:0] sel,
                      logic [31:0] d, string tg);
    exp_q.push_back({b, dn, er, we, sel, d});
    tag_q.push_back(tg);
  endtask

  task automatic build(bit flow, logic [MW-1:0] meth, int tmo, string jt);
    logic [31:0] prev, ctl;
    int d, te;
    prev = '0;
    te = (tmo < 1) ? 1 : tmo;
    for (int i = 0; i < N; i++) begin
      push(1, 0, 0, 0, 0, 0, {"R2 ", jt});
      push(1, 0, 0, 0, 0, 0, {"R2 ", jt});
      if (t_res[i] == 0) begin
        push(0, 1, 0, 0, 0, 0, {"R6 ", jt});
        push(0, 0, 0, 0, 0, 0, {"R1 ", jt});
        return;
      end
      if (i > 0) begin
        push(1, 0, 0, 1, K_KEY, prev, {"R3 ", jt});
        push(1, 0, 0, 1, K_IV, prev, {"R3 ", jt});
      end
      push(1, 0, 0, 1, K_SRC, t_src[i], {"R2 ", jt});
      push(1, 0, 0, 1, K_DST, t_res[i], {"R2 ", jt});
      push(1, 0, 0, 1, K_LEN, {16'd0, t_len[i]}, {"R5 ", jt});
      push(1, 0, 0, 1, K_IEN, 32'd3, {"R5 ", jt});
      ctl = 32'd1 | (32'(flow) << 1) | (32'(meth) << 4) | ((i > 0) ? 32'h2_0000 : 32'd0);
      push(1, 0, 0, 1, K_CTL, ctl, {"R4 R3 ", jt});
      d = dly[i];
      if (d == 0 || d > te) begin
        for (int w = 1; w < te; w++) push(1, 0, 0, 0, 0, 0, {"R7 ", jt});
        push(0, 0, 1, 0, 0, 0, {"R7 ", jt});
        push(0, 0, 0, 0, 0, 0, {"R7 ", jt});
        return;
      end
      for (int w = 1; w < d; w++) push(1, 0, 0, 0, 0, 0, {"R9 ", jt});
      prev = t_res[i];
      if (i == N - 1) begin
        push(0, 1, 0, 0, 0, 0, {"R6 ", jt});
        push(0, 0, 0, 0, 0, 0, {"R1 ", jt});
        return;
      end
    end
  endtask

  task automatic load_table();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = IDXW'(i);
      tbl_src_addr = t_src[i]; tbl_src_words = t_len[i]; tbl_res_addr = t_res[i];
    end
    @(negedge clk) tbl_we = 1'b0;
  endtask

  task automatic run_job(bit flow, logic [MW-1:0] meth, int tmo, bit stray,
                         int go_at, string jt);
    logic [38:0] e, a;
    string tg;
    int k, seg, step;
    bit waiting, dv;
    build(flow, meth, tmo, jt);
    @(negedge clk);
    job_flow = flow; job_method = meth; job_timeout = TW'(tmo); job_go = 1'b1;
    k = 0; seg = -1; step = 0; waiting = 0;
    while (exp_q.size() > 0) begin
      @(negedge clk);
      job_go = (step == go_at);
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      a = actual();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s step %0d actual %h expected %h", tg, step, a, e);
      end
      dv = 1'b0;
      if (eng_wr_en && eng_wr_sel == K_CTL) begin
        waiting = 1; k = 1; seg++;
      end else if (waiting) k++;
      if (waiting && seg >= 0 && seg < N && dly[seg] != 0 && k == dly[seg]) begin
        dv = 1'b1; waiting = 0;
      end
      if (stray && eng_wr_en && eng_wr_sel == K_SRC) dv = 1'b1;
      eng_done = dv;
      step++;
    end
    eng_done = 1'b0; job_go = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; tbl_we = 0; tbl_idx = 0; tbl_src_addr = 0; tbl_src_words = 0;
    tbl_res_addr = 0; job_go = 0; job_flow = 0; job_method = 0; job_timeout = 0;
    eng_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (actual() !== 39'd0) begin
      errors++;
      $display("FAIL R1 reset actual %h expected %h", actual(), 39'd0);
    end

    t_src = '{32'h1000, 32'h2000, 32'h3000, 32'h4000};
    t_len = '{16'd16, 16'd32, 16'd8, 16'd4};
    t_res = '{32'hA000, 32'hB000, 32'hC000, 32'h0};
    load_table();
    dly = '{2, 1, 5, 0};
    run_job(1'b0, 4'h5, 8, 1'b0, -1, "R2 chain stops on zero result");

    t_res[3] = 32'hD000;
    load_table();
    dly = '{3, 3, 3, 3};
    run_job(1'b1, 4'hA, 10, 1'b0, 5, "R1 full table, go while busy");

    dly = '{2, 0, 3, 3};
    run_job(1'b0, 4'h3, 4, 1'b0, -1, "R7 timeout on second segment");

    dly = '{4, 4, 4, 4};
    run_job(1'b1, 4'hF, 4, 1'b0, -1, "R9 completion on expiry cycle");

    dly = '{0, 0, 0, 0};
    run_job(1'b0, 4'h1, 3, 1'b1, -1, "R8 stray completion ignored");

    t_res[0] = 32'h0;
    load_table();
    run_job(1'b0, 4'h2, 5, 1'b0, -1, "R6 empty table");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule